// File: doc/BRIEF.md
# Flash backup command sequencer

This block is the save-memory controller of a cartridge-style subsystem. It takes byte writes on a 16-bit address space and watches them for a flash command protocol. A two-step unlock comes first: 0xAA at 0x5555, then 0x55 at 0x2AAA. A command byte written to 0x5555 follows. Through this protocol the block provides an identification mode, single-byte programming, 4KB-style sector erase, whole-chip erase and selection between two 64KB banks. All of these act on a small on-chip byte array.

Until 0xAA has been written to 0x5555 with the unlock step at zero, the block acts as a plain byte-wide SRAM. Every write lands directly in the array. Once that key has been seen, the block is a flash device for good, and only the command protocol changes the array.

Erases are carried out by an address sweep that writes one byte per cycle. A busy flag is raised for the whole sweep, and writes that arrive during it are dropped. A one-cycle dirty flag follows every byte that the array takes. The bank size is set by the parameter BANK_AW, which gives the address bits per bank. The default is kept small. At BANK_AW = 16 the block covers the full 2 x 64KB layout.

Top module: `fsave_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy, dirty, flash_det, id_active, size_128k and sram_64k are all 0, the selected bank is 0, and the unlock step is 0.
- R2: While flash_det is 0, every write stores wr_data at array index wr_addr[BANK_AW-1:0] of bank 0, with higher address bits ignored. A write to 0x5555 is also stored this way, unless it is the 0xAA key. rd_data, sampled after a clock edge, is the byte that was held before that edge at index rd_addr of the selected bank.
- R3: An SRAM-mode write with wr_addr[15] = 1 sets sram_64k, which then stays set until reset.
- R4: A write of 0xAA to 0x5555 with the unlock step at 0 sets flash_det, which stays set until reset, and the key byte is not stored. The sequence 0x55 at 0x2AAA moves the step from 1 to 2, and any byte written to 0x5555 at step 2 is a command that clears the step to 0. A command byte sent without a fresh unlock has no effect.
- R5: Command 0x90 enters ID mode (id_active = 1) and 0xF0 leaves it. The mode commands 0x90, 0x80, 0xA0 and 0xB0 take effect only from base mode, so 0xA0 sent in ID mode does not arm programming.
- R6: After command 0xA0, the next write that is not an unlock step stores its byte at {bank, wr_addr[BANK_AW-1:0]}, including a write to 0x5555, and returns to base mode. In flash base mode, a plain write does not change the array.
- R7: In erase mode (entered by 0x80), an unlock followed by 0x30 at any address fills with 0xFF the sector of 2^(BANK_AW-4) bytes in the current bank chosen by wr_addr[BANK_AW-1:BANK_AW-4]. busy is high for exactly one cycle per byte of the sector.
- R8: In erase mode, an unlock followed by 0x10 at 0x5555 fills with 0xFF bank 0 (2^BANK_AW bytes) when size_128k is 0, or both banks (2^(BANK_AW+1) bytes) when it is 1. busy is high for one cycle per byte.
- R9: Command 0xB0 sets size_128k, which stays set until reset, and enters bank-select mode. In that mode only a write to address 0x0000 selects the bank from wr_data[0] and returns to base mode. Writes to other addresses leave the mode unchanged.
- R10: Writes presented while busy is 1 are ignored entirely: they change neither the array nor the command state.
- R11: dirty is 1 in the cycle after each cycle in which the array takes a byte (SRAM write, program or erase step), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | BANK_AW | Read index within the selected bank |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Erase sweep in progress |
| dirty | output | 1 | Array was modified in the previous cycle |
| flash_det | output | 1 | Flash protocol has been detected |
| id_active | output | 1 | ID mode is active |
| size_128k | output | 1 | Device is treated as two banks |
| sram_64k | output | 1 | SRAM write above the 32KB boundary seen |

## Verification
Some properties are checked by the assertions on every cycle. The sticky flags never fall. ID mode is only ever entered from base mode. An erase never starts while a sweep is running. The command port stays quiet during busy. A running sweep advances one address per cycle without stopping early, and every busy cycle is followed by dirty. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These cases are the exact sector and chip extents and their busy lengths, address aliasing in SRAM mode, commands ignored outside base mode or without a fresh unlock, writes dropped during an erase, and data landing in the right bank after a switch.

// File: rtl/fsave_pkg.sv
// Shared types and protocol constants for the flash backup sequencer.
// Assumes a 16-bit write address and byte data.
package fsave_pkg;
    typedef enum logic [2:0] {
        M_BASE,
        M_ID,
        M_ERASE,
        M_PROG,
        M_BANK
    } fmode_t;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [7:0]  OP_ID      = 8'h90;
    localparam logic [7:0]  OP_ID_EXIT = 8'hF0;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  OP_PROG    = 8'hA0;
    localparam logic [7:0]  OP_BANK    = 8'hB0;
    localparam logic [7:0]  OP_CHIP    = 8'h10;
    localparam logic [7:0]  OP_SECT    = 8'h30;
endpackage

// File: rtl/fsave_seq.sv
// Command sequencer: decodes unlock steps and command bytes, and holds
// the mode, step, bank and detection flags. It issues single-byte array
// writes and erase range requests. It assumes the caller keeps busy high
// for the whole of a sweep, and it ignores writes while busy is high.
module fsave_seq
    import fsave_pkg::*;
#(
    parameter int BANK_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               busy,
    output logic               put_en,
    output logic [BANK_AW:0]   put_idx,
    output logic [7:0]         put_data,
    output logic               er_start,
    output logic [BANK_AW:0]   er_first,
    output logic [BANK_AW:0]   er_last,
    output logic               bank,
    output logic               flash_det,
    output logic               id_active,
    output logic               size_128k,
    output logic               sram_64k
);
    localparam int SECT_AW = BANK_AW - 4;

    fmode_t     mode, n_mode;
    logic [1:0] step, n_step;
    logic       n_flash, n_big, n_sram, n_bank;

    // Decode one write into the next state and the array actions.
    always_comb begin
        n_mode   = mode;
        n_step   = step;
        n_flash  = flash_det;
        n_big    = size_128k;
        n_sram   = sram_64k;
        n_bank   = bank;
        put_en   = 1'b0;
        put_idx  = {bank, wr_addr[BANK_AW-1:0]};
        put_data = wr_data;
        er_start = 1'b0;
        er_first = '0;
        er_last  = '0;
        if (wr_en && !busy) begin
            if (wr_addr == KEY_ADDR_A && mode != M_PROG) begin
                if (step == 2'd0 && wr_data == KEY_A) begin
                    n_flash = 1'b1;
                    n_step  = 2'd1;
                end else if (step == 2'd2) begin
                    n_step = 2'd0;
                    case (wr_data)
                        OP_ID:      if (mode == M_BASE) n_mode = M_ID;
                        OP_ERASE:   if (mode == M_BASE) n_mode = M_ERASE;
                        OP_ID_EXIT: if (mode == M_ID) n_mode = M_BASE;
                        OP_PROG:    if (mode == M_BASE) n_mode = M_PROG;
                        OP_BANK: begin
                            n_big = 1'b1;
                            if (mode == M_BASE) n_mode = M_BANK;
                        end
                        OP_CHIP: if (mode == M_ERASE) begin
                            er_start = 1'b1;
                            er_last  = size_128k ? '1 : {1'b0, {BANK_AW{1'b1}}};
                            n_mode   = M_BASE;
                        end
                        default: ;
                    endcase
                end
                if (!n_flash) put_en = 1'b1;
            end else if (wr_addr == KEY_ADDR_B && wr_data == KEY_B && step == 2'd1) begin
                n_step = 2'd2;
            end else if (step == 2'd2 && mode == M_ERASE && wr_data == OP_SECT) begin
                er_start = 1'b1;
                er_first = {bank, wr_addr[BANK_AW-1 -: 4], {SECT_AW{1'b0}}};
                er_last  = {bank, wr_addr[BANK_AW-1 -: 4], {SECT_AW{1'b1}}};
                n_mode   = M_BASE;
                n_step   = 2'd0;
            end else if (step == 2'd0 && mode == M_BANK && wr_addr == 16'h0000) begin
                n_bank = wr_data[0];
                n_mode = M_BASE;
            end else if (step == 2'd0 && mode == M_PROG) begin
                put_en = 1'b1;
                n_mode = M_BASE;
            end else if (!flash_det) begin
                put_en = 1'b1;
                if (wr_addr[15]) n_sram = 1'b1;
            end
        end
    end

    // Hold the protocol state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= M_BASE;
            step      <= 2'd0;
            flash_det <= 1'b0;
            size_128k <= 1'b0;
            sram_64k  <= 1'b0;
            bank      <= 1'b0;
        end else begin
            mode      <= n_mode;
            step      <= n_step;
            flash_det <= n_flash;
            size_128k <= n_big;
            sram_64k  <= n_sram;
            bank      <= n_bank;
        end
    end

    assign id_active = (mode == M_ID);

    // R4
    flash_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_det |=> flash_det);
    // R9
    big_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_128k |=> size_128k);
    // R3
    sram_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_64k |=> sram_64k);
    // R5
    id_from_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_active) |-> $past(mode) == M_BASE);
endmodule

// File: rtl/fsave_eraser.sv
// Erase sweep engine: on start it writes 0xFF to every index from first
// to last, one byte per cycle, holding busy high the whole time. It
// assumes first <= last and that no start arrives while busy.
module fsave_eraser #(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MEM_AW-1:0] first,
    input  logic [MEM_AW-1:0] last,
    output logic              busy,
    output logic [MEM_AW-1:0] ptr
);
    logic [MEM_AW-1:0] end_r;

    // Step the sweep pointer and drop busy after the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            ptr   <= '0;
            end_r <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ptr   <= first;
            end_r <= last;
        end else if (busy) begin
            if (ptr == end_r) busy <= 1'b0;
            else ptr <= ptr + 1'b1;
        end
    end

    // R10
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R7
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ptr != end_r) |=> (busy && ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/fsave_array.sv
// Byte backing array with one write port and a registered read port.
// The read returns the contents from before a same-edge write. dirty
// follows each accepted write by one cycle. Contents are not reset.
module fsave_array #(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] widx,
    input  logic [7:0]        wdata,
    input  logic [MEM_AW-1:0] ridx,
    output logic [7:0]        rd_data,
    output logic              dirty
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];

    // Store a byte and read the addressed byte.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
        rd_data <= mem[ridx];
    end

    // Flag a modification one cycle after it happens.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty <= 1'b0;
        else dirty <= we;
    end
endmodule

// File: rtl/fsave_ctrl.sv
// Top of the flash backup sequencer. It joins the command sequencer,
// the erase sweep engine and the byte array. Sweep writes and command
// writes never overlap, because the sequencer is quiet while busy.
module fsave_ctrl #(
    parameter int BANK_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [BANK_AW-1:0] rd_addr,
    output logic [7:0]         rd_data,
    output logic               busy,
    output logic               dirty,
    output logic               flash_det,
    output logic               id_active,
    output logic               size_128k,
    output logic               sram_64k
);
    localparam int MEM_AW = BANK_AW + 1;

    logic              put_en, er_start, bank;
    logic [MEM_AW-1:0] put_idx, er_first, er_last, er_ptr;
    logic [7:0]        put_data;
    logic              a_we;
    logic [MEM_AW-1:0] a_idx;
    logic [7:0]        a_data;

    fsave_seq #(.BANK_AW(BANK_AW)) i_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .put_en(put_en), .put_idx(put_idx),
        .put_data(put_data), .er_start(er_start), .er_first(er_first),
        .er_last(er_last), .bank(bank), .flash_det(flash_det),
        .id_active(id_active), .size_128k(size_128k), .sram_64k(sram_64k)
    );

    fsave_eraser #(.MEM_AW(MEM_AW)) i_eraser (
        .clk(clk), .rst_n(rst_n), .start(er_start), .first(er_first),
        .last(er_last), .busy(busy), .ptr(er_ptr)
    );

    // Select the sweep or the command write for the array port.
    always_comb begin
        a_we   = busy | put_en;
        a_idx  = busy ? er_ptr : put_idx;
        a_data = busy ? 8'hFF : put_data;
    end

    fsave_array #(.MEM_AW(MEM_AW)) i_array (
        .clk(clk), .rst_n(rst_n), .we(a_we), .widx(a_idx), .wdata(a_data),
        .ridx({bank, rd_addr}), .rd_data(rd_data), .dirty(dirty)
    );

    // R11
    erase_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> dirty);
    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !put_en);
endmodule

// File: tb/test_fsave_ctrl.sv
module test_fsave_ctrl;
    localparam int BAW = 6;
    localparam int B   = 1 << BAW;
    localparam int S   = B / 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [15:0]    wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [BAW-1:0] rd_addr = '0;
    logic [7:0]     rd_data;
    logic           busy, dirty, flash_det, id_active, size_128k, sram_64k;

    fsave_ctrl #(.BANK_AW(BAW)) i_fsave_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .dirty(dirty), .flash_det(flash_det), .id_active(id_active),
        .size_128k(size_128k), .sram_64k(sram_64k)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    started = 0;

    // Behavioural reference state.
    logic [7:0] mem_m [int];
    int         m_q [$];
    int         m_mode = 0;  // 0 base, 1 id, 2 erase, 3 prog, 4 bank
    int         m_step = 0;
    bit         m_flash = 0, m_big = 0, m_sram = 0, m_bank = 0, m_dirty = 0;
    bit         m_rd_known = 0;
    logic [7:0] m_rd = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_write(input int a, input int d);
        int bi;
        bi = m_bank * B + (a % B);
        if (a == 16'h5555 && m_mode != 3) begin
            if (m_step == 0 && d == 8'hAA) begin
                m_flash = 1;
                m_step = 1;
            end else if (m_step == 2) begin
                m_step = 0;
                if (d == 8'h90 && m_mode == 0) m_mode = 1;
                else if (d == 8'h80 && m_mode == 0) m_mode = 2;
                else if (d == 8'hF0 && m_mode == 1) m_mode = 0;
                else if (d == 8'hA0 && m_mode == 0) m_mode = 3;
                else if (d == 8'hB0) begin
                    if (m_mode == 0) m_mode = 4;
                    m_big = 1;
                end else if (d == 8'h10 && m_mode == 2) begin
                    for (int k = 0; k < (m_big ? 2 * B : B); k++) m_q.push_back(k);
                    m_mode = 0;
                end
            end
            if (!m_flash) begin
                mem_m[bi] = d[7:0];
                m_dirty = 1;
            end
        end else if (a == 16'h2AAA && d == 8'h55 && m_step == 1) begin
            m_step = 2;
        end else if (m_step == 2 && m_mode == 2 && d == 8'h30) begin
            for (int k = 0; k < S; k++) m_q.push_back(m_bank * B + ((a % B) / S) * S + k);
            m_mode = 0;
            m_step = 0;
        end else if (m_step == 0 && m_mode == 4 && a == 0) begin
            m_bank = d[0];
            m_mode = 0;
        end else if (m_step == 0 && m_mode == 3) begin
            mem_m[bi] = d[7:0];
            m_dirty = 1;
            m_mode = 0;
        end else if (!m_flash) begin
            mem_m[bi] = d[7:0];
            m_dirty = 1;
            if (a >= 16'h8000) m_sram = 1;
        end
    endtask

    // Advance the reference model on each clock edge.
    always @(posedge clk) begin
        int ri;
        ri = m_bank * B + int'(rd_addr);
        m_rd_known = mem_m.exists(ri);
        if (m_rd_known) m_rd = mem_m[ri];
        started = 1;
        m_dirty = 0;
        if (!rst_n) begin
            m_q.delete();
            m_mode = 0; m_step = 0; m_flash = 0; m_big = 0; m_sram = 0; m_bank = 0;
        end else if (m_q.size() > 0) begin
            mem_m[m_q.pop_front()] = 8'hFF;
            m_dirty = 1;
        end else if (wr_en) begin
            model_write(int'(wr_addr), int'(wr_data));
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (started) begin
            chk(busy == (m_q.size() > 0), {cur_req, " busy"}, busy, m_q.size() > 0);
            chk(dirty == m_dirty, {cur_req, " dirty R11"}, dirty, m_dirty);
            chk(flash_det == m_flash, {cur_req, " flash_det"}, flash_det, m_flash);
            chk(id_active == (m_mode == 1), {cur_req, " id_active"}, id_active, m_mode == 1);
            chk(size_128k == m_big, {cur_req, " size_128k"}, size_128k, m_big);
            chk(sram_64k == m_sram, {cur_req, " sram_64k"}, sram_64k, m_sram);
            if (m_rd_known)
                chk(rd_data === m_rd, {cur_req, " rd_data"}, rd_data, m_rd);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, c);
    endtask

    task automatic rd(input logic [BAW-1:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        @(negedge clk);
        chk(rd_data === exp, {tag, " read"}, rd_data, exp);
    endtask

    task automatic count_busy(input int already, input int exp, input string tag);
        int n;
        n = already;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, {tag, " busy length"}, n, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(!busy && !dirty && !flash_det && !id_active && !size_128k && !sram_64k,
            "R1 reset outputs", {busy, dirty, flash_det, id_active, size_128k, sram_64k}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R2";
        wr(16'h0010, 8'h3C);
        chk(dirty == 1'b1, "R11 dirty after sram write", dirty, 1);
        rd(6'h10, 8'h3C, "R2");
        wr(16'h0451, 8'h77);
        rd(6'h11, 8'h77, "R2 alias");
        wr(16'h5555, 8'h12);
        rd(6'h15, 8'h12, "R2 at 5555");
        wr(16'h0020, 8'h01);
        cur_req = "R3";
        chk(sram_64k == 1'b0, "R3 below boundary", sram_64k, 0);
        wr(16'h8005, 8'h99);
        chk(sram_64k == 1'b1, "R3 above boundary", sram_64k, 1);
        rd(6'h05, 8'h99, "R3");

        cur_req = "R4";
        wr(16'h5555, 8'hAA);
        chk(flash_det == 1'b1, "R4 detect", flash_det, 1);
        chk(dirty == 1'b0, "R4 key not stored", dirty, 0);
        rd(6'h15, 8'h12, "R4 key not stored");
        wr(16'h2AAA, 8'h55);
        cur_req = "R5";
        wr(16'h5555, 8'h90);
        chk(id_active == 1'b1, "R5 enter id", id_active, 1);
        cmd(8'hA0);
        cmd(8'hF0);
        chk(id_active == 1'b0, "R5 leave id", id_active, 0);
        wr(16'h0020, 8'h44);
        rd(6'h20, 8'h01, "R5 prog not armed from id");
        cur_req = "R4";
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'h90);
        chk(id_active == 1'b0, "R4 step cleared", id_active, 0);

        cur_req = "R6";
        cmd(8'hA0);
        wr(16'h0020, 8'h5A);
        chk(dirty == 1'b1, "R11 dirty after program", dirty, 1);
        rd(6'h20, 8'h5A, "R6 program");
        wr(16'h0020, 8'h66);
        rd(6'h20, 8'h5A, "R6 single program");
        cmd(8'hA0);
        wr(16'h5555, 8'hC3);
        rd(6'h15, 8'hC3, "R6 program at 5555");
        cmd(8'hA0);
        wr(16'h0024, 8'h11);
        cmd(8'hA0);
        wr(16'h0028, 8'h22);

        cur_req = "R7";
        cmd(8'h80);
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h1226, 8'h30);
        count_busy(0, S, "R7");
        rd(6'h24, 8'hFF, "R7 sector erased");
        rd(6'h28, 8'h22, "R7 next sector kept");
        rd(6'h20, 8'h5A, "R7 prior sector kept");

        cur_req = "R8";
        cmd(8'h80);
        cmd(8'h10);
        cur_req = "R10";
        cmd(8'hA0);
        count_busy(3, B, "R8 bank0 only");
        wr(16'h0001, 8'h5D);
        rd(6'h01, 8'hFF, "R10 writes during busy ignored");
        rd(6'h28, 8'hFF, "R8 chip erased");

        cur_req = "R9";
        cmd(8'hB0);
        chk(size_128k == 1'b1, "R9 size flag", size_128k, 1);
        wr(16'h0004, 8'h01);
        wr(16'h0000, 8'h01);
        cmd(8'hA0);
        wr(16'h0003, 8'h7E);
        rd(6'h03, 8'h7E, "R9 bank1 program");
        cmd(8'hB0);
        wr(16'h0000, 8'h00);
        rd(6'h03, 8'hFF, "R9 bank0 view");
        cmd(8'hB0);
        wr(16'h0000, 8'h01);
        rd(6'h03, 8'h7E, "R9 bank1 view");

        cur_req = "R8";
        cmd(8'h80);
        cmd(8'h10);
        count_busy(0, 2 * B, "R8 both banks");
        rd(6'h03, 8'hFF, "R8 bank1 erased");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule